// File: doc/BRIEF.md
# Column Lifecycle Challenge Selector

This block decides which challenge a verifier may issue next to a crossbar-based unclonable function. A challenge names one column of the array and two distinct rows of that column. Every challenge answered from a column reveals a little about that column's devices. The block therefore rations challenges per column. Each column is Secure (never used), InUse (being drawn from, below its budget) or Retired (budget spent). At most one column is InUse at any time.

On a request strobe the block issues the next unused row pair of the open column. If no column is open, it first opens one. To open a column it draws a candidate from the random input and accepts it only if that column is still Secure. After a bounded number of rejections it falls back to the lowest-numbered Secure column. The per-column budget comes from a threshold input that is latched when the column opens. When the budget is spent the column is retired for good. Once no Secure or InUse column remains, the block raises an exhausted flag and refuses further requests.

Top module: `chal_sel_top`

## Requirements
- R1: After reset every column is Secure, no challenge is being presented (`chal_valid_o`=0) and `exhausted_o`=0.
- R2: Every issued challenge has `chal_row_a_o` != `chal_row_b_o`. Both rows are below NUM_ROWS and the column is below NUM_COLS.
- R3: When a request finds no open column, the candidate column is `rnd_i % NUM_COLS`. If that candidate is Secure it is opened, and the row offset is `(rnd_i >> RND_W/2) % NUM_ROWS`, sampled in the same cycle.
- R4: A candidate that is not Secure is rejected, and a new candidate is drawn on the next cycle. After MAX_RETRY consecutive rejections the lowest-indexed Secure column is opened instead.
- R5: The k-th challenge (k from 0) from a column uses the k-th pair (a,b), a<b, in ascending order: (0,1),(0,2),…,(0,M-1),(1,2),…. Each row is mapped to (row+offset) mod NUM_ROWS. No pair repeats within a column.
- R6: The budget is `thresh_i` as sampled when the column opens, clamped to the range 1 … NUM_ROWS·(NUM_ROWS-1)/2 (0 counts as 1). After exactly that many challenges the column is retired, and the next request opens a new column.
- R7: A Retired column is never issued from or reopened.
- R8: `exhausted_o` is 1 exactly when no Secure column remains and no column is open. While it is 1, requests produce no challenge.
- R9: Each accepted request yields exactly one single-cycle `chal_valid_o` pulse. A request strobe that arrives while a previous request is still being served is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe for one challenge |
| thresh_i | input | THR_W | Per-column challenge budget, sampled when a column opens |
| rnd_i | input | RND_W | Random word for column choice and row offset |
| chal_valid_o | output | 1 | One-cycle pulse: challenge outputs are valid |
| chal_col_o | output | COL_W | Column of the issued challenge |
| chal_row_a_o | output | ROW_W | First row of the issued challenge |
| chal_row_b_o | output | ROW_W | Second row of the issued challenge |
| exhausted_o | output | 1 | No column can supply further challenges |

## Verification
The bench builds the block with four columns and four rows, which gives six pairs per column, and with MAX_RETRY of 3 and a 4-bit threshold. With these values every column can be driven to retirement within a short run. One column is walked through all six pairs, and the offset rotation wraps around the row count. Thresholds of 0 and 9 exercise both ends of the clamp. A candidate that points at a retired column forces the fallback scan, and the final state reaches exhaustion and refusal.

// File: rtl/chal_sel_pkg.sv
package chal_sel_pkg;

    typedef enum logic [1:0] {
        COL_SECURE  = 2'd0,
        COL_INUSE   = 2'd1,
        COL_RETIRED = 2'd2
    } col_state_e;

    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_PICK  = 2'd1,
        SEL_SCAN  = 2'd2,
        SEL_ISSUE = 2'd3
    } sel_fsm_e;

    function automatic int pair_total(input int rows);
        return rows * (rows - 1) / 2;
    endfunction

endpackage

// File: rtl/chal_sel_col_table.sv
module chal_sel_col_table
    import chal_sel_pkg::*;
#(
    parameter int NUM_COLS = 8,
    parameter int COL_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_en,
    input  logic [COL_W-1:0] open_idx,
    input  logic             retire_en,
    input  logic [COL_W-1:0] retire_idx,
    input  logic [COL_W-1:0] query_idx,
    output col_state_e       query_state,
    output logic             any_secure,
    output logic [COL_W-1:0] first_secure
);

    col_state_e st_q [NUM_COLS];
    logic [NUM_COLS-1:0] secure_vec;
    logic [NUM_COLS-1:0] inuse_vec;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_COLS; i++) begin
            if (rst)
                st_q[i] <= COL_SECURE;
            else if (open_en && open_idx == COL_W'(i))
                st_q[i] <= COL_INUSE;
            else if (retire_en && retire_idx == COL_W'(i))
                st_q[i] <= COL_RETIRED;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_COLS; i++) begin
            secure_vec[i] = (st_q[i] == COL_SECURE);
            inuse_vec[i]  = (st_q[i] == COL_INUSE);
        end
    end

    always_comb begin
        first_secure = '0;
        for (int j = NUM_COLS - 1; j >= 0; j--)
            if (secure_vec[j]) first_secure = COL_W'(j);
    end

    assign any_secure  = |secure_vec;
    assign query_state = st_q[query_idx];

    // R6: a single column is open at a time
    p_single_open_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(inuse_vec) <= 1);

    generate
        for (genvar g = 0; g < NUM_COLS; g++) begin : g_col_chk
            // R7: retirement is permanent
            p_retired_sticky_r7: assert property (@(posedge clk) disable iff (rst)
                st_q[g] == COL_RETIRED |=> st_q[g] == COL_RETIRED);
            // R3: a Secure column only leaves that state by being opened
            p_secure_to_open_r3: assert property (@(posedge clk) disable iff (rst)
                st_q[g] == COL_SECURE |=> st_q[g] == COL_SECURE || st_q[g] == COL_INUSE);
        end
    endgenerate

endmodule

// File: rtl/chal_sel_pair_walker.sv
module chal_sel_pair_walker #(
    parameter int NUM_ROWS = 8,
    parameter int ROW_W    = 3,
    parameter int CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [ROW_W-1:0] row_a,
    output logic [ROW_W-1:0] row_b,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
    localparam logic [ROW_W-1:0] PEN_ROW  = ROW_W'(NUM_ROWS - 2);
    localparam int               PAIRS    = NUM_ROWS * (NUM_ROWS - 1) / 2;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            row_a <= '0;
            row_b <= ROW_W'(1);
            cnt   <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
            if (row_b == LAST_ROW) begin
                if (row_a != PEN_ROW) begin
                    row_a <= row_a + 1'b1;
                    row_b <= row_a + ROW_W'(2);
                end
            end else begin
                row_b <= row_b + 1'b1;
            end
        end
    end

    // R5: while pairs remain, the walker holds a strictly ordered pair
    p_pair_ordered_r5: assert property (@(posedge clk) disable iff (rst)
        (32'(cnt) < PAIRS) |-> (row_a < row_b && row_b <= LAST_ROW));

endmodule

// File: rtl/chal_sel_top.sv
module chal_sel_top
    import chal_sel_pkg::*;
#(
    parameter int NUM_COLS  = 8,
    parameter int NUM_ROWS  = 8,
    parameter int THR_W     = 6,
    parameter int RND_W     = 16,
    parameter int MAX_RETRY = 4,
    localparam int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int ROW_W    = $clog2(NUM_ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [THR_W-1:0] thresh_i,
    input  logic [RND_W-1:0] rnd_i,
    output logic             chal_valid_o,
    output logic [COL_W-1:0] chal_col_o,
    output logic [ROW_W-1:0] chal_row_a_o,
    output logic [ROW_W-1:0] chal_row_b_o,
    output logic             exhausted_o
);

    localparam int               PAIRS    = pair_total(NUM_ROWS);
    localparam logic [THR_W-1:0] PAIRS_T  = THR_W'(PAIRS);
    localparam int               RETRY_W  = $clog2(MAX_RETRY + 1);
    localparam int               RND_HALF = RND_W / 2;
    localparam logic [ROW_W:0]   ROWS_X   = (ROW_W + 1)'(NUM_ROWS);

    sel_fsm_e           state_q;
    logic [RETRY_W-1:0] retry_q;
    logic [COL_W-1:0]   cur_col_q;
    logic [ROW_W-1:0]   off_q;
    logic [THR_W-1:0]   eff_q;
    logic               have_col_q;

    logic [COL_W-1:0]   cand;
    logic [ROW_W-1:0]   off_rnd;
    logic [THR_W-1:0]   eff_thr;
    col_state_e         cand_state;
    logic               any_secure;
    logic [COL_W-1:0]   first_secure;
    logic               open_en;
    logic [COL_W-1:0]   open_idx;
    logic               retire_en;
    logic               last_issue;
    logic [ROW_W-1:0]   walk_a, walk_b;
    logic [THR_W-1:0]   walk_cnt;

    assign cand    = COL_W'(rnd_i % RND_W'(NUM_COLS));
    assign off_rnd = ROW_W'((rnd_i >> RND_HALF) % RND_W'(NUM_ROWS));

    always_comb begin
        if (thresh_i == '0)
            eff_thr = THR_W'(1);
        else if (thresh_i > PAIRS_T)
            eff_thr = PAIRS_T;
        else
            eff_thr = thresh_i;
    end

    function automatic logic [ROW_W-1:0] rotate(input logic [ROW_W-1:0] r,
                                                input logic [ROW_W-1:0] o);
        logic [ROW_W:0] s;
        s = {1'b0, r} + {1'b0, o};
        if (s >= ROWS_X) s = s - ROWS_X;
        return s[ROW_W-1:0];
    endfunction

    assign open_en    = (state_q == SEL_PICK && cand_state == COL_SECURE) ||
                        (state_q == SEL_SCAN && any_secure);
    assign open_idx   = (state_q == SEL_PICK) ? cand : first_secure;
    assign last_issue = (walk_cnt + 1'b1) == eff_q;
    assign retire_en  = (state_q == SEL_ISSUE) && last_issue;

    chal_sel_col_table #(
        .NUM_COLS(NUM_COLS),
        .COL_W   (COL_W)
    ) u_table (
        .clk         (clk),
        .rst         (rst),
        .open_en     (open_en),
        .open_idx    (open_idx),
        .retire_en   (retire_en),
        .retire_idx  (cur_col_q),
        .query_idx   (cand),
        .query_state (cand_state),
        .any_secure  (any_secure),
        .first_secure(first_secure)
    );

    chal_sel_pair_walker #(
        .NUM_ROWS(NUM_ROWS),
        .ROW_W   (ROW_W),
        .CNT_W   (THR_W)
    ) u_walker (
        .clk  (clk),
        .rst  (rst),
        .clear(open_en),
        .step (state_q == SEL_ISSUE),
        .row_a(walk_a),
        .row_b(walk_b),
        .cnt  (walk_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SEL_IDLE;
            retry_q      <= '0;
            cur_col_q    <= '0;
            off_q        <= '0;
            eff_q        <= THR_W'(1);
            have_col_q   <= 1'b0;
            chal_valid_o <= 1'b0;
            chal_col_o   <= '0;
            chal_row_a_o <= '0;
            chal_row_b_o <= '0;
        end else begin
            chal_valid_o <= 1'b0;
            case (state_q)
                SEL_IDLE: begin
                    if (req_i && !exhausted_o) begin
                        retry_q <= '0;
                        state_q <= have_col_q ? SEL_ISSUE : SEL_PICK;
                    end
                end
                SEL_PICK: begin
                    if (cand_state == COL_SECURE) begin
                        cur_col_q  <= cand;
                        off_q      <= off_rnd;
                        eff_q      <= eff_thr;
                        have_col_q <= 1'b1;
                        state_q    <= SEL_ISSUE;
                    end else if (retry_q == RETRY_W'(MAX_RETRY - 1)) begin
                        state_q <= SEL_SCAN;
                    end else begin
                        retry_q <= retry_q + 1'b1;
                    end
                end
                SEL_SCAN: begin
                    if (any_secure) begin
                        cur_col_q  <= first_secure;
                        off_q      <= off_rnd;
                        eff_q      <= eff_thr;
                        have_col_q <= 1'b1;
                        state_q    <= SEL_ISSUE;
                    end else begin
                        state_q <= SEL_IDLE;
                    end
                end
                SEL_ISSUE: begin
                    chal_valid_o <= 1'b1;
                    chal_col_o   <= cur_col_q;
                    chal_row_a_o <= rotate(walk_a, off_q);
                    chal_row_b_o <= rotate(walk_b, off_q);
                    if (last_issue) have_col_q <= 1'b0;
                    state_q <= SEL_IDLE;
                end
                default: state_q <= SEL_IDLE;
            endcase
        end
    end

    assign exhausted_o = !have_col_q && !any_secure;

    // R2: the two rows of a challenge always differ
    p_rows_differ_r2: assert property (@(posedge clk) disable iff (rst)
        chal_valid_o |-> chal_row_a_o != chal_row_b_o);

    // R8: nothing is issued once exhaustion has been flagged
    p_refuse_when_empty_r8: assert property (@(posedge clk) disable iff (rst)
        $past(exhausted_o) |-> !chal_valid_o);

    // R6: the open column never exceeds its latched budget
    p_budget_bound_r6: assert property (@(posedge clk) disable iff (rst)
        have_col_q |-> walk_cnt < eff_q);

    // R4: the retry counter stays inside its bound
    p_retry_bound_r4: assert property (@(posedge clk) disable iff (rst)
        retry_q < RETRY_W'(MAX_RETRY));

    // R9: each result is a single-cycle pulse
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        chal_valid_o |=> !chal_valid_o);

endmodule

// File: tb/tb_chal_sel_top.sv
`timescale 1ns/1ps
module tb_chal_sel_top;

    localparam int NC = 4;
    localparam int NR = 4;
    localparam int TW = 4;
    localparam int RW = 16;
    localparam int PAIRS = NR * (NR - 1) / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_i = 1'b0;
    logic [TW-1:0] thresh_i = '0;
    logic [RW-1:0] rnd_i = '0;
    logic          chal_valid_o;
    logic [1:0]    chal_col_o;
    logic [1:0]    chal_row_a_o, chal_row_b_o;
    logic          exhausted_o;

    always #2.5 clk = ~clk;

    chal_sel_top #(
        .NUM_COLS(NC), .NUM_ROWS(NR), .THR_W(TW), .RND_W(RW), .MAX_RETRY(3)
    ) dut (
        .clk(clk), .rst(rst), .req_i(req_i), .thresh_i(thresh_i), .rnd_i(rnd_i),
        .chal_valid_o(chal_valid_o), .chal_col_o(chal_col_o),
        .chal_row_a_o(chal_row_a_o), .chal_row_b_o(chal_row_b_o),
        .exhausted_o(exhausted_o)
    );

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];
    bit used [NC][NR][NR];

    // reference model state: 0 Secure, 1 open, 2 retired
    int m_st[NC];
    int m_have = 0, m_col = 0, m_off = 0, m_eff = 1, m_cnt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int model_exh();
        int any = 0;
        for (int i = 0; i < NC; i++) if (m_st[i] == 0) any = 1;
        return (m_have == 0 && any == 0) ? 1 : 0;
    endfunction

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && chal_valid_o) begin
            int act;
            act = {chal_col_o, 6'b0, chal_row_a_o, 6'b0, chal_row_b_o};
            chk(chal_row_a_o != chal_row_b_o, "R2 rows distinct", act, 0);
            chk(!used[chal_col_o][chal_row_a_o][chal_row_b_o], "R5 no repeated pair", act, 0);
            used[chal_col_o][chal_row_a_o][chal_row_b_o] = 1'b1;
            used[chal_col_o][chal_row_b_o][chal_row_a_o] = 1'b1;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8/R9 unexpected challenge", act, 0);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(act == e, t, act, e);
            end
        end
    end

    task automatic do_req(input logic [RW-1:0] rnd, input int thr,
                          input bit dbl, input string tag);
        if (model_exh() == 0) begin
            int a, b, k, ra, rb;
            if (m_have == 0) begin
                int c;
                c = int'(rnd) % NC;
                if (m_st[c] != 0) begin
                    c = -1;
                    for (int i = NC - 1; i >= 0; i--) if (m_st[i] == 0) c = i;
                end
                m_col = c;
                m_off = (int'(rnd) >> 8) % NR;
                m_eff = (thr == 0) ? 1 : (thr > PAIRS ? PAIRS : thr);
                m_cnt = 0;
                m_st[c] = 1;
                m_have = 1;
            end
            k = 0; ra = 0; rb = 1;
            for (int x = 0; x < NR; x++)
                for (int y = x + 1; y < NR; y++) begin
                    if (k == m_cnt) begin ra = x; rb = y; end
                    k++;
                end
            a = (ra + m_off) % NR;
            b = (rb + m_off) % NR;
            exp_q.push_back((m_col << 16) | (a << 8) | b);
            tag_q.push_back(tag);
            m_cnt++;
            if (m_cnt == m_eff) begin
                m_st[m_col] = 2;
                m_have = 0;
            end
        end
        @(negedge clk);
        rnd_i = rnd;
        thresh_i = TW'(thr);
        req_i = 1'b1;
        @(negedge clk);
        if (dbl) @(negedge clk);
        req_i = 1'b0;
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " result delivered"}, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        chk(exhausted_o == model_exh(), "R8 exhausted flag", exhausted_o, model_exh());
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NC; i++) m_st[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(chal_valid_o == 1'b0, "R1 no challenge after reset", chal_valid_o, 0);
        chk(exhausted_o == 1'b0, "R1 not exhausted after reset", exhausted_o, 0);

        // R3: direct candidate 2, offset 1, budget 2; second threshold ignored (R6 latch)
        do_req(16'h0102, 2, 1'b0, "R3 random column pick");
        do_req(16'h0000, 5, 1'b0, "R6 latched budget second pair");
        // R4/R7: candidate 2 now retired -> fallback to lowest Secure (0), offset 3
        do_req(16'h0302, 1, 1'b0, "R4 fallback scan after rejects");
        // R6: threshold 0 clamps to 1; candidate 1
        do_req(16'h0001, 0, 1'b0, "R6 zero threshold clamp");
        // R5: threshold 9 clamps to 6; full walk of column 3 with offset 2
        do_req(16'h0203, 9, 1'b0, "R5 pair order k0");
        do_req(16'h0000, 0, 1'b1, "R9 double strobe single issue");
        for (int n = 2; n < PAIRS; n++)
            do_req(16'h0000, 0, 1'b0, "R5 pair order walk");
        // R8: everything retired, requests refused
        do_req(16'h0001, 3, 1'b0, "R8 refused request");
        chk(exhausted_o == 1'b1, "R8 exhausted held", exhausted_o, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule